// File: doc/BRIEF.md
# Time-over-threshold counter with serial readout

This block measures how long a comparator output stays high during one charge-injection cycle. It counts cycles of a fast clock while the comparator is high and clears the count whenever injection is inactive. The length of the pulse above threshold, in fast-clock cycles, is then a measure of the injected charge. Both inputs are asynchronous, so each one passes through a two-flop synchroniser before it reaches the counter. The count saturates at full scale instead of wrapping.

A host reads the result over a simple serial link made of SCLK, CS_B and MISO. The CS_B level selects the kind of frame: low is a read frame and high is a write frame. On entry to a read frame the block copies the live count into a shadow register. A bit pointer then walks that copy MSB first and moves one bit on each falling SCLK edge, so each bit is stable when the host samples it on the rising edge. The host lines are also synchronised into the fast-clock domain. SCLK must therefore run well below the fast clock, with each SCLK phase lasting several fast-clock cycles.

Top module: `tot_readout`

## Requirements
- R1: While injection is active, the count rises by exactly one for every fast-clock cycle the comparator is high. The count is 8 bits wide. A comparator pulse of N cycles gives a count of N, after two cycles of synchroniser delay.
- R2: While the comparator is low, the count holds its value. Separate pulses within one injection cycle therefore add up.
- R3: Once the count reaches 255 it stays at 255 for as long as injection stays active.
- R4: While the injection input is low, the count is forced to 0. Comparator activity during that time is not counted.
- R5: CS_B low marks a read frame. MISO presents the captured count MSB first (bit 7, then bit 6, and so on), one bit per SCLK period. A bit is valid before the rising SCLK edge, and the pointer advances to the next bit on the falling edge.
- R6: The count is copied into a shadow register when CS_B goes low. Counting that happens during the frame does not change the bits sent in that frame.
- R7: Every change of CS_B returns the bit pointer to bit 7. A frame that is cut short and then restarted begins again with the MSB.
- R8: MISO is low whenever CS_B is high (a write frame), even if SCLK is toggling.
- R9: After the eighth falling SCLK edge of a read frame, MISO stays low until the frame ends.
- R10: After reset, the count is 0 and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkFast | input | 1 | Fast counting clock; all state is clocked by it |
| rstN | input | 1 | Asynchronous active-low reset |
| compIn | input | 1 | Comparator output, asynchronous |
| injIn | input | 1 | Injection-active level, asynchronous |
| sclk | input | 1 | Host serial clock |
| csB | input | 1 | Frame select: low = read frame, high = write frame |
| miso | output | 1 | Serial count output to the host |

## Verification
The bench aims at off-by-one errors at the synchroniser boundary: a one-cycle pulse must count exactly 1, and a wrong gate would count 0 or 2. It drives pulses long enough to pass 255, so a counter that wraps would report a small value instead of full scale. It feeds extra comparator pulses into the middle of a read frame; a design without the shadow register would send a mix of old and new bits. It also aborts a frame and restarts it, where a pointer that is not reset would start at the wrong bit. Finally, it checks that MISO stays low after the eighth bit and during write frames, where a design would otherwise wrap the pointer or leak the count.

// File: rtl/tot_pkg.sv
package tot_pkg;

  // Strobes and levels sent from the control side to the datapath.
  typedef struct packed {
    logic compOn;    // synchronised comparator level
    logic injOn;     // synchronised injection-active level
    logic capture;   // copy count into shadow (start of read frame)
    logic readOn;    // a read frame is in progress
    logic ptrReset;  // frame-select changed: pointer back to MSB
    logic ptrStep;   // falling serial-clock edge: advance pointer
  } totCtl_t;

endpackage

// File: rtl/tot_sync.sv
module tot_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/tot_ctrl.sv
module tot_ctrl
  import tot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    compIn,
  input  logic    injIn,
  input  logic    sclk,
  input  logic    csB,
  output totCtl_t ctl
);

  // Bit order of the synchroniser bus.
  localparam int B_COMP = 0;
  localparam int B_INJ  = 1;
  localparam int B_CS   = 2;
  localparam int B_SCLK = 3;
  localparam int N_IN   = 4;
  // The frame-select input rests high (no read frame) out of reset.
  localparam logic [N_IN-1:0] SYNC_RST = N_IN'(1) << B_CS;

  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] syncIn;
  logic            csSync;
  logic            sclkSync;
  logic            csPrev;
  logic            sclkPrev;
  logic            readFlag;

  assign rawIn[B_COMP] = compIn;
  assign rawIn[B_INJ]  = injIn;
  assign rawIn[B_CS]   = csB;
  assign rawIn[B_SCLK] = sclk;

  tot_sync #(
    .WIDTH  (N_IN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawIn),
    .dout(syncIn)
  );

  assign csSync   = syncIn[B_CS];
  assign sclkSync = syncIn[B_SCLK];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
      readFlag <= 1'b0;
    end else begin
      csPrev   <= csSync;
      sclkPrev <= sclkSync;
      readFlag <= ~csSync;
    end
  end

  always_comb begin
    ctl.compOn   = syncIn[B_COMP];
    ctl.injOn    = syncIn[B_INJ];
    ctl.capture  = csPrev & ~csSync;
    ctl.readOn   = readFlag;
    ctl.ptrReset = csPrev ^ csSync;
    ctl.ptrStep  = sclkPrev & ~sclkSync;
  end

endmodule

// File: rtl/tot_datapath.sv
module tot_datapath
  import tot_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int PTR_W = $clog2(CNT_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  totCtl_t          ctl,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] shadow,
  output logic [PTR_W-1:0] ptr,
  output logic             miso
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(CNT_W - 1);

  logic bitsDone;

  // Counter gated by the comparator, cleared outside injection, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (!ctl.injOn) begin
      count <= '0;
    end else if (ctl.compOn && count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end

  // Shadow copy, frozen for the duration of a read frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow <= '0;
    end else if (ctl.capture) begin
      shadow <= count;
    end
  end

  // Bit pointer, MSB first; stops after the LSB has been sent.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= PTR_TOP;
      bitsDone <= 1'b0;
    end else if (ctl.ptrReset) begin
      ptr      <= PTR_TOP;
      bitsDone <= 1'b0;
    end else if (ctl.ptrStep && !bitsDone) begin
      if (ptr == '0) begin
        bitsDone <= 1'b1;
      end else begin
        ptr <= ptr - 1'b1;
      end
    end
  end

  assign miso = ctl.readOn & ~bitsDone & shadow[ptr];

endmodule

// File: rtl/tot_readout.sv
module tot_readout
  import tot_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W = $clog2(CNT_W)
) (
  input  logic clkFast,
  input  logic rstN,
  input  logic compIn,
  input  logic injIn,
  input  logic sclk,
  input  logic csB,
  output logic miso
);

  totCtl_t          ctl;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] shadow;
  logic [PTR_W-1:0] ptr;

  tot_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk   (clkFast),
    .rstN  (rstN),
    .compIn(compIn),
    .injIn (injIn),
    .sclk  (sclk),
    .csB   (csB),
    .ctl   (ctl)
  );

  tot_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk   (clkFast),
    .rstN  (rstN),
    .ctl   (ctl),
    .count (count),
    .shadow(shadow),
    .ptr   (ptr),
    .miso  (miso)
  );

endmodule

// File: rtl/tot_readout_chk.sv
module tot_readout_chk
  import tot_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PTR_W = 3
) (
  input logic             clkFast,
  input logic             rstN,
  input logic             csB,
  input logic             miso,
  input totCtl_t          ctl,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] shadow,
  input logic [PTR_W-1:0] ptr
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(CNT_W - 1);

  p_step_r1: assert property (@(posedge clkFast) disable iff (!rstN)
    (ctl.injOn && ctl.compOn && count != CNT_MAX) |=> count == $past(count) + 1'b1);

  p_hold_r2: assert property (@(posedge clkFast) disable iff (!rstN)
    (ctl.injOn && !ctl.compOn) |=> $stable(count));

  p_no_overflow_r3: assert property (@(posedge clkFast) disable iff (!rstN)
    (ctl.injOn && count == CNT_MAX) |=> count == CNT_MAX);

  p_clear_r4: assert property (@(posedge clkFast) disable iff (!rstN)
    !ctl.injOn |=> count == '0);

  p_frozen_r6: assert property (@(posedge clkFast) disable iff (!rstN)
    (ctl.readOn && !ctl.capture) |=> $stable(shadow));

  p_ptr_top_r7: assert property (@(posedge clkFast) disable iff (!rstN)
    ctl.ptrReset |=> ptr == PTR_TOP);

  p_quiet_write_r8: assert property (@(posedge clkFast) disable iff (!rstN)
    (csB && $past(csB) && $past(csB, 2) && $past(csB, 3)) |-> !miso);

endmodule

bind tot_readout tot_readout_chk #(
  .CNT_W(CNT_W),
  .PTR_W(PTR_W)
) u_chk (
  .clkFast(clkFast),
  .rstN   (rstN),
  .csB    (csB),
  .miso   (miso),
  .ctl    (ctl),
  .count  (count),
  .shadow (shadow),
  .ptr    (ptr)
);

// File: tb/tot_readout_tb.sv
`timescale 1ns/1ps
module tot_readout_tb;

  localparam int HALF = 10;  // fast cycles per serial-clock phase

  logic clkFast = 1'b0;
  logic rstN    = 1'b0;
  logic compIn  = 1'b0;
  logic injIn   = 1'b0;
  logic sclk    = 1'b0;
  logic csB     = 1'b1;
  logic miso;

  int  total = 0;
  int  bad   = 0;
  bit  ended = 1'b0;

  always #10 clkFast = ~clkFast;  // 50 MHz

  tot_readout u_dut (
    .clkFast(clkFast),
    .rstN   (rstN),
    .compIn (compIn),
    .injIn  (injIn),
    .sclk   (sclk),
    .csB    (csB),
    .miso   (miso)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clkFast);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    compIn = 1'b1;
    waitCyc(n);
    compIn = 1'b0;
    waitCyc(4);
  endtask

  task automatic newInjection();
    injIn = 1'b0;
    waitCyc(5);
    injIn = 1'b1;
    waitCyc(5);
  endtask

  // Read frame: bits sampled just before each rising edge. Optional comparator
  // pulse inserted after bit index midAt (0 = none).
  task automatic readFrame(input int nBits, input int midAt, input int midLen,
                           output logic [7:0] val, output bit tailLow);
    val = '0;
    tailLow = 1'b1;
    csB = 1'b0;
    for (int i = 0; i < nBits; i++) begin
      waitCyc(HALF);
      val[7-i] = miso;
      sclk = 1'b1;
      waitCyc(HALF);
      sclk = 1'b0;
      if (midAt != 0 && i == midAt - 1) pulse(midLen);
    end
    if (nBits == 8) begin
      for (int k = 0; k < 3; k++) begin
        waitCyc(HALF);
        if (miso !== 1'b0) tailLow = 1'b0;
        sclk = 1'b1;
        waitCyc(HALF);
        sclk = 1'b0;
      end
    end
    csB = 1'b1;
    waitCyc(HALF);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bit tl;
    check(miso === 1'b0, "R10 miso after reset", int'(miso), 0);
    readFrame(8, 0, 0, v, tl);
    check(v == 8'd0, "R10 count after reset", v, 0);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    bit tl;
    newInjection();
    pulse(37);
    readFrame(8, 0, 0, v, tl);
    check(v == 8'd37, "R1 R5 single pulse", v, 37);
    check(tl, "R9 miso low after 8 bits", int'(tl), 1);
    newInjection();
    pulse(1);
    readFrame(8, 0, 0, v, tl);
    check(v == 8'd1, "R1 one-cycle pulse", v, 1);
    newInjection();
    pulse(128);
    readFrame(8, 0, 0, v, tl);
    check(v == 8'd128, "R5 msb only", v, 128);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    bit tl;
    newInjection();
    pulse(100);
    waitCyc(30);
    pulse(65);
    readFrame(8, 0, 0, v, tl);
    check(v == 8'd165, "R2 two pulses add", v, 165);
  endtask

  task automatic t_saturate();
    logic [7:0] v;
    bit tl;
    newInjection();
    pulse(300);
    readFrame(8, 0, 0, v, tl);
    check(v == 8'd255, "R3 saturation", v, 255);
    pulse(20);
    readFrame(8, 0, 0, v, tl);
    check(v == 8'd255, "R3 stays full scale", v, 255);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    bit tl;
    newInjection();
    pulse(50);
    injIn = 1'b0;
    waitCyc(5);
    pulse(40);
    readFrame(8, 0, 0, v, tl);
    check(v == 8'd0, "R4 cleared while injection low", v, 0);
    injIn = 1'b1;
    waitCyc(5);
    readFrame(8, 0, 0, v, tl);
    check(v == 8'd0, "R4 starts from zero", v, 0);
  endtask

  task automatic t_shadow();
    logic [7:0] v;
    bit tl;
    newInjection();
    pulse(20);
    readFrame(8, 3, 30, v, tl);
    check(v == 8'd20, "R6 frame value frozen", v, 20);
    readFrame(8, 0, 0, v, tl);
    check(v == 8'd50, "R6 next frame sees new count", v, 50);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    bit tl;
    newInjection();
    pulse(8'hC9);
    readFrame(3, 0, 0, v, tl);
    check(v[7:5] == 3'b110, "R7 partial frame msb bits", v[7:5], 6);
    readFrame(8, 0, 0, v, tl);
    check(v == 8'hC9, "R7 restarted frame from msb", v, 201);
  endtask

  task automatic t_write();
    bit seenHigh = 1'b0;
    newInjection();
    pulse(255);
    csB = 1'b1;
    for (int i = 0; i < 10; i++) begin
      waitCyc(HALF);
      if (miso !== 1'b0) seenHigh = 1'b1;
      sclk = 1'b1;
      waitCyc(HALF);
      if (miso !== 1'b0) seenHigh = 1'b1;
      sclk = 1'b0;
    end
    check(!seenHigh, "R8 miso low in write frame", int'(seenHigh), 0);
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);
    t_reset();
    t_basic();
    t_hold();
    t_saturate();
    t_clear();
    t_shadow();
    t_restart();
    t_write();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clkFast);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule